// File: doc/BRIEF.md
# Fixed-Point Scaled Timestamp Counter

This block produces a 64-bit system timestamp for downstream timers. It keeps an 88-bit accumulator holding an unsigned 64.24 fixed-point value. Every clock cycle in which the counter is running, the accumulator advances by one step. The step is either exactly one visible count or a programmable 32-bit increment in units of 2^-24. This lets a counter clocked at one rate present a timestamp at another nominal rate. Only the integer part, accumulator bits [87:24], is visible. It is driven on `count_o` and is readable over the register port.

Software reaches the block through a simple 32-bit read/write port. The port has a window select, so it can address two 4 KB windows. The control window holds:

- the control word,
- the two count halves, which are writable,
- the scale increment and its alias,
- a constant capability word,
- a block of identification bytes.

The status window is read-only. It shows the two count halves and its own identification bytes. Read data is registered, and it returns zero in any cycle that follows no read.

Top module: `fxc_counter_top`

## Requirements
- R1: After reset, `count_o` is 0, the control word reads 0 and the scale word reads 0x01000000.
- R2: With control bit 0 (run) set and bit 2 (scale enable) clear, `count_o` rises by exactly 1 on every clock edge, carrying from the low into the high 32 bits.
- R3: With run and scale enable both set, every edge adds the 32-bit scale word to the 88-bit accumulator, and `count_o` is accumulator bits [87:24]. A scale word written while running is used from the edge after the write.
- R4: With run clear, `count_o` holds its value.
- R5: Control window offset 0x000 stores write bits [4:0] (bit 0 run, bit 1 debug halt, bit 2 scale enable, bit 3 interrupt mask, bit 4 error disable). Bits [31:5] always read zero.
- R6: Control window offsets 0x008 and 0x00C read and write the low and high halves of the count. A write replaces only that half, keeps the other half, clears the 24 fraction bits, and takes precedence over the tick on that edge.
- R7: The scale word is read and written at control offsets 0x010 and 0x0D0, which share one register. Offset 0x0D4 reads zero and ignores writes.
- R8: Control offset 0x004 reads 0 and offset 0x01C reads 0x00020001. Writes to both are ignored.
- R9: The word offsets 0xFD0..0xFFC of each window read one identification byte each, in this order: 0x04,0,0,0, then 0xBA,0xB0,0x0B,0x00 (0xBB first in the status window), then 0x0D,0xF0,0x05,0xB1.
- R10: Status window (`win_i`=1) offset 0x000 reads the count's low half and 0x004 its high half. Every status-window write is ignored.
- R11: Offsets not listed, and any address with bits [1:0] nonzero, read zero and ignore writes.
- R12: `rdata_o` carries the value addressed by a read on the edge after the request, taken from state before that edge. It is zero after any edge without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; each edge is one counter tick |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled on the rising edge |
| we_i | input | 1 | 1 = write, 0 = read |
| win_i | input | 1 | 0 = control window, 1 = status window |
| addr_i | input | 12 | Byte offset within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| count_o | output | 64 | Visible integer part of the count |

## Verification
A write lands on the edge that samples it. The next edge is the first one that uses the new control or scale value. A count-half write is visible on `count_o` just after its own edge, because the load wins over that edge's tick. A run-bit clear still lets that same edge tick once.

Read data appears one edge after the request and reflects the state before that edge. The bench therefore drives requests at the falling edge and samples `rdata_o` and `count_o` 1 ns after the next rising edge. It predicts each counter value from the number of edges elapsed since a known load. The scaled tests use a half-unit increment, so a fraction left uncleared would shift the integer sequence by a cycle.

// File: rtl/fxc_pkg.sv
`timescale 1ns/1ps
package fxc_pkg;
  localparam int AW = 12;

  localparam logic [AW-1:0] OFF_CTRL    = 12'h000;
  localparam logic [AW-1:0] OFF_STAT    = 12'h004;
  localparam logic [AW-1:0] OFF_CNT_LO  = 12'h008;
  localparam logic [AW-1:0] OFF_CNT_HI  = 12'h00C;
  localparam logic [AW-1:0] OFF_SCALE_A = 12'h010;
  localparam logic [AW-1:0] OFF_CAPS    = 12'h01C;
  localparam logic [AW-1:0] OFF_SCALE_B = 12'h0D0;
  localparam logic [AW-1:0] OFF_SCALE_X = 12'h0D4;
  localparam logic [AW-1:0] SOFF_LO     = 12'h000;
  localparam logic [AW-1:0] SOFF_HI     = 12'h004;

  localparam logic [31:0] CAPS_WORD = 32'h0002_0001;

  typedef enum logic {WIN_CTRL = 1'b0, WIN_STAT = 1'b1} win_e;

  typedef struct packed {
    logic err_dis;
    logic irq_mask;
    logic scale_en;
    logic dbg_halt;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/fxc_ctrl_regs.sv
`timescale 1ns/1ps
module fxc_ctrl_regs
  import fxc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SCALE_W = 32,
  parameter int FRAC_W  = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  logic               scale_we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output ctrl_t              ctrl_o,
  output logic [SCALE_W-1:0] scale_o
);
  localparam logic [SCALE_W-1:0] SCALE_ONE = SCALE_W'(1) << FRAC_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      scale_o <= SCALE_ONE;
    end else begin
      if (ctrl_we_i)  ctrl_o  <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (scale_we_i) scale_o <= wdata_i[SCALE_W-1:0];
    end
  end

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(ctrl_o)); // R5
  AST_SCALE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scale_we_i |=> $stable(scale_o)); // R7
endmodule

// File: rtl/fxc_accum.sv
`timescale 1ns/1ps
module fxc_accum #(
  parameter int INT_W   = 64,
  parameter int FRAC_W  = 24,
  parameter int SCALE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               scale_en_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic               load_lo_i,
  input  logic               load_hi_i,
  input  logic [INT_W/2-1:0] load_data_i,
  output logic [INT_W-1:0]   count_o
);
  localparam int ACC_W  = INT_W + FRAC_W;
  localparam int HALF_W = INT_W / 2;

  logic [ACC_W-1:0] acc_q, step;
  logic [INT_W-1:0] load_val;
  logic             load;

  assign count_o = acc_q[ACC_W-1:FRAC_W];
  assign load    = load_lo_i | load_hi_i;

  always_comb begin
    step = scale_en_i ? ACC_W'(scale_i) : (ACC_W'(1) << FRAC_W);
    load_val = count_o;
    if (load_lo_i) load_val[HALF_W-1:0]     = load_data_i;
    if (load_hi_i) load_val[INT_W-1:HALF_W] = load_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (load)  acc_q <= {load_val, {FRAC_W{1'b0}}};
    else if (run_i) acc_q <= acc_q + step;
  end

  AST_PLAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !scale_en_i && !load |=> count_o == $past(count_o) + 1'b1); // R2
  AST_SCALED_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && scale_en_i && !load |=> acc_q == $past(acc_q) + ACC_W'($past(scale_i))); // R3
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !load |=> $stable(acc_q)); // R4
  AST_LOAD_FRAC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> acc_q[FRAC_W-1:0] == '0); // R6
  AST_LOAD_KEEP_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_lo_i && !load_hi_i |=> count_o[INT_W-1:HALF_W] == $past(count_o[INT_W-1:HALF_W])); // R6
endmodule

// File: rtl/fxc_id_rom.sv
`timescale 1ns/1ps
module fxc_id_rom (
  input  logic       stat_win_i,
  input  logic [3:0] idx_i,
  output logic [7:0] byte_o
);
  always_comb begin
    unique case (idx_i)
      4'd0:    byte_o = 8'h04;
      4'd4:    byte_o = stat_win_i ? 8'hBB : 8'hBA;
      4'd5:    byte_o = 8'hB0;
      4'd6:    byte_o = 8'h0B;
      4'd8:    byte_o = 8'h0D;
      4'd9:    byte_o = 8'hF0;
      4'd10:   byte_o = 8'h05;
      4'd11:   byte_o = 8'hB1;
      default: byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/fxc_counter_top.sv
`timescale 1ns/1ps
module fxc_counter_top
  import fxc_pkg::*;
#(
  parameter int INT_W   = 64,
  parameter int FRAC_W  = 24,
  parameter int SCALE_W = 32,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              win_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [INT_W-1:0]  count_o
);
  localparam int HALF_W = INT_W / 2;

  ctrl_t              ctrl;
  logic [SCALE_W-1:0] scale;
  logic               aligned, in_id, ctrl_wr;
  logic               ctrl_we, scale_we, load_lo, load_hi;
  logic [3:0]         id_idx;
  logic [7:0]         id_byte;
  logic [DATA_W-1:0]  rd_val;

  assign aligned = addr_i[1:0] == 2'b00;
  assign in_id   = addr_i[AW-1:6] == '1 && addr_i[5:2] >= 4'd4;
  assign id_idx  = addr_i[5:2] - 4'd4;
  assign ctrl_wr = req_i && we_i && aligned && win_e'(win_i) == WIN_CTRL;

  assign ctrl_we  = ctrl_wr && addr_i == OFF_CTRL;
  assign scale_we = ctrl_wr && (addr_i == OFF_SCALE_A || addr_i == OFF_SCALE_B);
  assign load_lo  = ctrl_wr && addr_i == OFF_CNT_LO;
  assign load_hi  = ctrl_wr && addr_i == OFF_CNT_HI;

  fxc_ctrl_regs #(.DATA_W(DATA_W), .SCALE_W(SCALE_W), .FRAC_W(FRAC_W)) u_regs (
    .clk_i, .rst_ni,
    .ctrl_we_i (ctrl_we),
    .scale_we_i(scale_we),
    .wdata_i,
    .ctrl_o    (ctrl),
    .scale_o   (scale)
  );

  fxc_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W), .SCALE_W(SCALE_W)) u_acc (
    .clk_i, .rst_ni,
    .run_i      (ctrl.run),
    .scale_en_i (ctrl.scale_en),
    .scale_i    (scale),
    .load_lo_i  (load_lo),
    .load_hi_i  (load_hi),
    .load_data_i(wdata_i[HALF_W-1:0]),
    .count_o
  );

  fxc_id_rom u_id (
    .stat_win_i(win_i),
    .idx_i     (id_idx),
    .byte_o    (id_byte)
  );

  always_comb begin
    rd_val = '0;
    if (!aligned) begin
      rd_val = '0;
    end else if (in_id) begin
      rd_val = DATA_W'(id_byte);
    end else if (win_e'(win_i) == WIN_STAT) begin
      unique case (addr_i)
        SOFF_LO: rd_val = count_o[HALF_W-1:0];
        SOFF_HI: rd_val = count_o[INT_W-1:HALF_W];
        default: rd_val = '0;
      endcase
    end else begin
      unique case (addr_i)
        OFF_CTRL:                 rd_val = DATA_W'(ctrl);
        OFF_CNT_LO:               rd_val = count_o[HALF_W-1:0];
        OFF_CNT_HI:               rd_val = count_o[INT_W-1:HALF_W];
        OFF_SCALE_A, OFF_SCALE_B: rd_val = DATA_W'(scale);
        OFF_CAPS:                 rd_val = CAPS_WORD;
        default:                  rd_val = '0; // status, second scale, holes
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rdata_o <= '0;
    else if (req_i && !we_i) rdata_o <= rd_val;
    else                    rdata_o <= '0;
  end

  AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> rdata_o == '0); // R12
  AST_STAT_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && win_i && !ctrl.run |=> $stable(count_o)); // R10
  AST_MISALIGNED_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && addr_i[1:0] != 2'b00 |=> rdata_o == '0); // R11
endmodule

// File: tb/fxc_counter_top_tb_top.sv
`timescale 1ns/1ps
module fxc_counter_top_tb_top;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, win = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [63:0] count;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fxc_counter_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .win_i(win),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .count_o(count)
  );

  logic [7:0] exp_id_c [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'hBA, 8'hB0, 8'h0B, 8'h00,
                                8'h0D, 8'hF0, 8'h05, 8'hB1};
  logic [7:0] exp_id_s [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'hBB, 8'hB0, 8'h0B, 8'h00,
                                8'h0D, 8'hF0, 8'h05, 8'hB1};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; win = w; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic w, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; win = w; addr = a;
    @(posedge clk); #1;
    d = rdata;
    req = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 count after reset", count, 64'h0);
    rd(1'b0, 12'h000, d); chk("R1 control after reset", d, 0);
    rd(1'b0, 12'h010, d); chk("R1 scale after reset", d, 32'h0100_0000);
    ticks(3);
    chk("R4 idle count holds", count, 64'h0);
  endtask

  task automatic t_ctrl_fields;
    logic [31:0] d;
    wr(1'b0, 12'h000, 32'hFFFF_FFFE);
    rd(1'b0, 12'h000, d); chk("R5 control field mask", d, 32'h1E);
    wr(1'b0, 12'h000, 32'h0);
    rd(1'b0, 12'h000, d); chk("R5 control cleared", d, 32'h0);
    chk("R4 no run, count still 0", count, 64'h0);
  endtask

  task automatic t_halves;
    logic [31:0] d;
    wr(1'b0, 12'h00C, 32'h1234_5678);
    wr(1'b0, 12'h008, 32'h9ABC_DEF0);
    chk("R6 count after half writes", count, 64'h1234_5678_9ABC_DEF0);
    rd(1'b0, 12'h008, d); chk("R6 low half read", d, 32'h9ABC_DEF0);
    rd(1'b0, 12'h00C, d); chk("R6 high half read", d, 32'h1234_5678);
    wr(1'b0, 12'h008, 32'h1);
    chk("R6 high half kept", count, 64'h1234_5678_0000_0001);
  endtask

  task automatic t_plain;
    wr(1'b0, 12'h010, 32'h0080_0000);
    wr(1'b0, 12'h00C, 32'h0);
    wr(1'b0, 12'h008, 32'hFFFF_FFFD);
    wr(1'b0, 12'h000, 32'h1);
    chk("R2 no tick on enable edge", count, 64'hFFFF_FFFD);
    ticks(5);
    chk("R2 plain count with carry", count, 64'h1_0000_0002);
    wr(1'b0, 12'h000, 32'h0);
    chk("R4 disable edge still ticks", count, 64'h1_0000_0003);
    ticks(4);
    chk("R4 count holds when stopped", count, 64'h1_0000_0003);
  endtask

  task automatic t_scaled;
    logic [63:0] c0;
    wr(1'b0, 12'h00C, 32'h0);
    wr(1'b0, 12'h008, 32'h0);
    wr(1'b0, 12'h000, 32'h5);
    ticks(4); chk("R3 half step x4", count, 64'd2);
    ticks(1); chk("R3 fraction hidden", count, 64'd2);
    ticks(1); chk("R3 half step x6", count, 64'd3);
    ticks(1);
    wr(1'b0, 12'h008, 32'd100);
    chk("R6 load wins over tick", count, 64'd100);
    ticks(1); chk("R6 fraction cleared, step 1", count, 64'd100);
    ticks(1); chk("R6 fraction cleared, step 2", count, 64'd101);
    wr(1'b0, 12'h0D0, 32'h0300_0000);
    c0 = count;
    ticks(1); chk("R3 new scale next tick", count, c0 + 3);
    ticks(2); chk("R3 new scale sustained", count, c0 + 9);
    wr(1'b0, 12'h000, 32'h0);
  endtask

  task automatic t_scale_alias;
    logic [31:0] d;
    wr(1'b0, 12'h0D0, 32'h00AB_CDEF);
    rd(1'b0, 12'h010, d); chk("R7 alias read", d, 32'h00AB_CDEF);
    wr(1'b0, 12'h0D4, 32'hFFFF_FFFF);
    rd(1'b0, 12'h0D4, d); chk("R7 second scale reads 0", d, 32'h0);
    rd(1'b0, 12'h0D0, d); chk("R7 scale unchanged", d, 32'h00AB_CDEF);
    wr(1'b0, 12'h010, 32'h0100_0000);
  endtask

  task automatic t_ident;
    logic [31:0] d;
    rd(1'b0, 12'h004, d); chk("R8 status word 0", d, 32'h0);
    rd(1'b0, 12'h01C, d); chk("R8 caps word", d, 32'h0002_0001);
    wr(1'b0, 12'h01C, 32'h0);
    wr(1'b0, 12'h004, 32'hFFFF_FFFF);
    rd(1'b0, 12'h01C, d); chk("R8 caps after write", d, 32'h0002_0001);
    rd(1'b0, 12'h004, d); chk("R8 status after write", d, 32'h0);
    for (int i = 0; i < 12; i++) begin
      rd(1'b0, 12'hFD0 + 12'(4 * i), d); chk("R9 control id byte", d, {24'h0, exp_id_c[i]});
      rd(1'b1, 12'hFD0 + 12'(4 * i), d); chk("R9 status id byte", d, {24'h0, exp_id_s[i]});
    end
  endtask

  task automatic t_status;
    logic [31:0] d;
    wr(1'b0, 12'h00C, 32'hCAFE_F00D);
    wr(1'b0, 12'h008, 32'h1234_5678);
    rd(1'b1, 12'h000, d); chk("R10 status low", d, 32'h1234_5678);
    rd(1'b1, 12'h004, d); chk("R10 status high", d, 32'hCAFE_F00D);
    wr(1'b1, 12'h000, 32'h0);
    wr(1'b1, 12'h004, 32'h0);
    chk("R10 status writes ignored", count, 64'hCAFE_F00D_1234_5678);
    wr(1'b1, 12'h008, 32'h0);
    chk("R10 status hole write ignored", count, 64'hCAFE_F00D_1234_5678);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(1'b0, 12'h020, d); chk("R11 hole 0x020", d, 32'h0);
    rd(1'b0, 12'h500, d); chk("R11 hole 0x500", d, 32'h0);
    rd(1'b1, 12'h008, d); chk("R11 status hole", d, 32'h0);
    rd(1'b0, 12'h009, d); chk("R11 misaligned read", d, 32'h0);
    wr(1'b0, 12'h001, 32'h1);
    rd(1'b0, 12'h000, d); chk("R11 misaligned write ignored", d, 32'h0);
    wr(1'b0, 12'h00A, 32'h0);
    chk("R11 misaligned count write ignored", count, 64'hCAFE_F00D_1234_5678);
  endtask

  task automatic t_read_timing;
    logic [31:0] d;
    logic [63:0] pre;
    wr(1'b0, 12'h000, 32'h1);
    pre = count;
    rd(1'b0, 12'h008, d);
    chk("R12 read returns pre-edge count", d, pre[31:0]);
    chk("R12 count moved on read edge", count, pre + 1);
    ticks(1);
    chk("R12 rdata idle zero", rdata, 32'h0);
    wr(1'b0, 12'h000, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_ctrl_fields();
    t_halves();
    t_plain();
    t_scaled();
    t_scale_alias();
    t_ident();
    t_status();
    t_unmapped();
    t_read_timing();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule